// File: doc/BRIEF.md
# Streaming Block Reversal Buffer

This block accepts a continuous stream of data words and sends them out again in segments of a fixed length, with the word order inside every segment reversed. It is meant to sit in front of the backward recursion of a windowed soft-output trellis decoder, which has to walk each window from its end towards its start. A second copy placed after the backward stage puts the words back into their arrival order.

Storage is two banks with one write port and one read port each. Incoming words fill one bank at rising addresses while the other bank is read out at falling addresses. The banks change roles whenever a segment is complete, so input and output can both move one word per clock. A segment is normally `BLK_LEN` words long. An input end marker closes a shorter final segment, which is then reversed over its real length. Both sides use a valid/ready handshake, and a stalled output pushes back onto the input without losing any words.

Top module: `blk_rev_buf`

## Requirements
- R1: Every segment of `BLK_LEN` consecutive accepted words leaves the block in reverse order: the word accepted last in the segment comes out first, and the word accepted first comes out last.
- R2: With `in_valid` held high and `out_ready` held high, the block accepts a word on every clock and emits a word on every clock once output has started. Input and output each move N words in N consecutive cycles.
- R3: With continuous input into an empty block, `out_valid` first rises exactly `BLK_LEN` cycles after the cycle in which the first word was accepted.
- R4: An accepted word with `in_last` = 1 closes the current segment at its actual length L (1 ≤ L ≤ `BLK_LEN`). The L words are emitted in reverse order, and the next word accepted starts a new segment.
- R5: `out_last` is 1 only on the final emitted word of a segment that was closed by `in_last` = 1. It is 0 on every other word, including every word of a segment that closed on reaching `BLK_LEN` without the marker.
- R6: When both banks hold segments that have not been fully read, `in_ready` is 0. In particular, with `out_ready` held low the block accepts exactly 2·`BLK_LEN` words and then holds `in_ready` low. No accepted word is lost or duplicated.
- R7: While `out_valid` = 1 and `out_ready` = 0, on the next cycle `out_valid` stays 1 and `out_data` and `out_last` are unchanged.
- R8: During and directly after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | DATA_W | Input word |
| in_last | input | 1 | Input word closes the current segment early |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | DATA_W | Output word |
| out_last | output | 1 | Final word of a segment closed by the end marker |

## Verification
The bench uses an 8-word segment. A gap-free stream of full segments with output always ready tests sustained one-word-per-cycle flow and the exact first-output delay, and separates a correct bank swap from one that loses a cycle at each boundary. A run of short and exact-length segments with end markers, from 1 to 8 words long, tests partial-length reversal and the placement of the end flag on the output. A fully stalled output tests the two-segment capacity limit and that held data stays stable. Finally, a long run with both valid and ready gated by pseudo-random patterns and random end markers tests that the ordering and boundary bookkeeping hold up under arbitrary interleaving.

// File: rtl/blk_rev_pkg.sv
package blk_rev_pkg;

  localparam int unsigned NUM_BANKS = 2;

  typedef logic bank_sel_t;

  function automatic bank_sel_t flip_bank(input bank_sel_t b);
    return bank_sel_t'(~b);
  endfunction

endpackage

// File: rtl/blk_rev_bank.sv
module blk_rev_bank #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[wr_addr] <= wr_data;
    end
  end

  assign rd_data = store[rd_addr];

endmodule

// File: rtl/blk_rev_wctl.sv
module blk_rev_wctl
  import blk_rev_pkg::*;
#(
  parameter int unsigned BLK_LEN = 64,
  localparam int unsigned AW     = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1,
  localparam int unsigned LW     = $clog2(BLK_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_last,
  input  logic [NUM_BANKS-1:0] bank_full,
  output logic                 in_ready,
  output logic                 wr_en,
  output bank_sel_t            wr_bank,
  output logic [AW-1:0]        wr_addr,
  output logic                 seal,
  output logic [LW-1:0]        seal_len,
  output logic                 seal_last
);

  bank_sel_t     bank_d;
  logic [AW-1:0] addr_d;
  logic          at_end;

  assign in_ready  = ~bank_full[wr_bank];
  assign wr_en     = in_valid & in_ready;
  assign at_end    = (wr_addr == AW'(BLK_LEN - 1));
  assign seal      = wr_en & (in_last | at_end);
  assign seal_len  = LW'(wr_addr) + LW'(1);
  assign seal_last = in_last;

  always_comb begin
    bank_d = wr_bank;
    addr_d = wr_addr;
    if (seal) begin
      bank_d = flip_bank(wr_bank);
      addr_d = '0;
    end else if (wr_en) begin
      addr_d = wr_addr + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bank <= '0;
      wr_addr <= '0;
    end else if (wr_en) begin
      wr_bank <= bank_d;
      wr_addr <= addr_d;
    end
  end

  // R4: a closed segment always restarts filling at the lowest address
  p_addr_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seal |=> (wr_addr == '0));

  // R4: a sealed length lies within one segment
  p_seal_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seal |-> (seal_len >= LW'(1)) && (seal_len <= LW'(BLK_LEN)));

endmodule

// File: rtl/blk_rev_rctl.sv
module blk_rev_rctl
  import blk_rev_pkg::*;
#(
  parameter int unsigned BLK_LEN = 64,
  localparam int unsigned AW     = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1,
  localparam int unsigned LW     = $clog2(BLK_LEN + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          out_ready,
  input  logic [NUM_BANKS-1:0]          bank_full,
  input  logic [NUM_BANKS-1:0][LW-1:0]  bank_len,
  input  logic [NUM_BANKS-1:0]          bank_last,
  output logic                          out_valid,
  output logic                          out_last,
  output bank_sel_t                     rd_bank,
  output logic [AW-1:0]                 rd_addr,
  output logic                          release_blk
);

  logic [AW-1:0] rpos_q, rpos_d;
  bank_sel_t     bank_d;
  logic [LW-1:0] cur_len;
  logic [LW-1:0] addr_wide;
  logic          final_item;
  logic          take;

  assign cur_len    = bank_len[rd_bank];
  assign addr_wide  = cur_len - LW'(1) - LW'(rpos_q);
  assign rd_addr    = addr_wide[AW-1:0];
  assign final_item = ((LW'(rpos_q) + LW'(1)) == cur_len);
  assign out_valid  = bank_full[rd_bank];
  assign take       = out_valid & out_ready;
  assign out_last   = out_valid & bank_last[rd_bank] & final_item;
  assign release_blk = take & final_item;

  always_comb begin
    bank_d = rd_bank;
    rpos_d = rpos_q;
    if (release_blk) begin
      bank_d = flip_bank(rd_bank);
      rpos_d = '0;
    end else if (take) begin
      rpos_d = rpos_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bank <= '0;
      rpos_q  <= '0;
    end else if (take) begin
      rd_bank <= bank_d;
      rpos_q  <= rpos_d;
    end
  end

  // R7: a stalled output keeps pointing at the same word
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(rd_addr) && $stable(rd_bank));

  // R5: the end flag only appears on the word stored first in the segment
  p_last_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (rd_addr == '0));

endmodule

// File: rtl/blk_rev_buf.sv
module blk_rev_buf
  import blk_rev_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned BLK_LEN = 64,
  localparam int unsigned AW     = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1,
  localparam int unsigned LW     = $clog2(BLK_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);

  logic [NUM_BANKS-1:0]          full_q, full_d;
  logic [NUM_BANKS-1:0][LW-1:0]  len_q, len_d;
  logic [NUM_BANKS-1:0]          endf_q, endf_d;

  logic                          wr_en;
  bank_sel_t                     wr_bank;
  logic [AW-1:0]                 wr_addr;
  logic                          seal;
  logic [LW-1:0]                 seal_len;
  logic                          seal_last;

  bank_sel_t                     rd_bank;
  logic [AW-1:0]                 rd_addr;
  logic                          release_blk;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd;

  blk_rev_wctl #(.BLK_LEN(BLK_LEN)) u_wctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .bank_full (full_q),
    .in_ready  (in_ready),
    .wr_en     (wr_en),
    .wr_bank   (wr_bank),
    .wr_addr   (wr_addr),
    .seal      (seal),
    .seal_len  (seal_len),
    .seal_last (seal_last)
  );

  blk_rev_rctl #(.BLK_LEN(BLK_LEN)) u_rctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_ready   (out_ready),
    .bank_full   (full_q),
    .bank_len    (len_q),
    .bank_last   (endf_q),
    .out_valid   (out_valid),
    .out_last    (out_last),
    .rd_bank     (rd_bank),
    .rd_addr     (rd_addr),
    .release_blk (release_blk)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    blk_rev_bank #(.DATA_W(DATA_W), .DEPTH(BLK_LEN)) u_bank (
      .clk     (clk),
      .wr_en   (wr_en && (wr_bank == bank_sel_t'(g))),
      .wr_addr (wr_addr),
      .wr_data (in_data),
      .rd_addr (rd_addr),
      .rd_data (bank_rd[g])
    );
  end

  assign out_data = bank_rd[rd_bank];

  always_comb begin
    full_d = full_q;
    len_d  = len_q;
    endf_d = endf_q;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (release_blk && (rd_bank == bank_sel_t'(b))) begin
        full_d[b] = 1'b0;
      end
      if (seal && (wr_bank == bank_sel_t'(b))) begin
        full_d[b] = 1'b1;
        len_d[b]  = seal_len;
        endf_d[b] = seal_last;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      len_q  <= '0;
      endf_q <= '0;
    end else if (seal || release_blk) begin
      full_q <= full_d;
      len_q  <= len_d;
      endf_q <= endf_d;
    end
  end

  // R6: a segment is never sealed into a bank still awaiting readout
  p_seal_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seal |-> !full_q[wr_bank]);

  // R1: only a bank holding a complete segment is released
  p_release_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    release_blk |-> full_q[rd_bank]);

  // R6: both banks occupied means the input is closed
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (&full_q) |-> !in_ready);

  // R7: stalled output data and end flag do not move
  p_out_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data) && $stable(out_last));

endmodule

// File: tb/blk_rev_buf_tb.sv
module blk_rev_buf_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int BL = 8;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] in_data;
  logic          in_last;
  logic          out_valid;
  logic          out_ready;
  logic [DW-1:0] out_data;
  logic          out_last;

  blk_rev_buf #(.DATA_W(DW), .BLK_LEN(BL)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int cyc    = 0;
  int rdy_mode = 0;

  logic [DW-1:0] exp_d [0:1023];
  bit            exp_l [0:1023];
  int            exp_n = 0;
  int            got_n = 0;
  logic [DW-1:0] blk_buf [0:BL-1];
  int            blk_cnt = 0;
  logic [DW-1:0] seq = 16'h1000;
  logic [15:0]   lfsr_in = 16'hACE1;
  logic [15:0]   lfsr_rd = 16'h5A5A;

  int first_acc, last_acc, first_out, last_out, first_vld;
  bit pv, pr, pl;
  logic [DW-1:0] pd;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // reference model: close segment at full length or end marker, reverse it
  task automatic model_push(input logic [DW-1:0] d, input bit l);
    blk_buf[blk_cnt] = d;
    blk_cnt++;
    if (l || blk_cnt == BL) begin
      for (int j = blk_cnt - 1; j >= 0; j--) begin
        exp_d[exp_n] = blk_buf[j];
        exp_l[exp_n] = l && (j == 0);
        exp_n++;
      end
      blk_cnt = 0;
    end
  endtask

  task automatic drive(input logic [DW-1:0] d, input bit l);
    bit acc = 0;
    in_valid = 1'b1;
    in_data  = d;
    in_last  = l;
    while (!acc) begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic send(input bit l, input int gap);
    model_push(seq, l);
    drive(seq, l);
    seq = seq + 16'd3;
    repeat (gap) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wait_drain();
    int t = 0;
    while (got_n < exp_n && t < 3000) begin
      @(posedge clk);
      t++;
    end
    #1;
    chk(got_n == exp_n, "R6", "words delivered", got_n, exp_n);
  endtask

  task automatic clear_track();
    first_acc = -1; last_acc = -1;
    first_out = -1; last_out = -1; first_vld = -1;
  endtask

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // output ready generator
  initial begin
    out_ready = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: begin
          lfsr_rd   = step(lfsr_rd);
          out_ready = lfsr_rd[0] | lfsr_rd[3];
        end
        default: out_ready = 1'b0;
      endcase
    end
  end

  // monitor, sampling mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr) begin
        chk(out_valid && out_data == pd && out_last == pl, "R7",
            "held output data", longint'(out_data), longint'(pd));
      end
      if (in_valid && in_ready) begin
        if (first_acc < 0) first_acc = cyc;
        last_acc = cyc;
      end
      if (out_valid && first_vld < 0) first_vld = cyc;
      if (out_valid && out_ready) begin
        if (got_n >= exp_n) begin
          chk(1'b0, "R6", "unexpected extra word", got_n, exp_n);
        end else begin
          chk(out_data == exp_d[got_n], "R1/R4", "reversed data",
              longint'(out_data), longint'(exp_d[got_n]));
          chk(out_last == exp_l[got_n], "R5", "end flag",
              longint'(out_last), longint'(exp_l[got_n]));
        end
        if (first_out < 0) first_out = cyc;
        last_out = cyc;
        got_n++;
      end
      pv = out_valid; pr = out_ready; pd = out_data; pl = out_last;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", got_n, exp_n);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    in_last = 1'b0;
    pv = 0; pr = 0; pl = 0; pd = '0;
    clear_track();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R8", "in_ready in reset", in_ready, 1);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);
    @(posedge clk);
    #1;

    // Phase A: gap-free full segments, output always ready (R1 R2 R3)
    rdy_mode = 0;
    repeat (2) begin @(posedge clk); #1; end
    clear_track();
    for (int i = 0; i < 4 * BL; i++) send(1'b0, 0);
    wait_drain();
    chk(first_vld - first_acc == BL, "R3", "first output delay",
        first_vld - first_acc, BL);
    chk(last_acc - first_acc == 4 * BL - 1, "R2", "input cycles",
        last_acc - first_acc, 4 * BL - 1);
    chk(last_out - first_out == 4 * BL - 1, "R2", "output cycles",
        last_out - first_out, 4 * BL - 1);

    // Phase B: short segments closed by the marker (R4 R5)
    for (int len = 1; len <= BL; len++) begin
      for (int i = 0; i < len; i++) send(i == len - 1, (len % 3 == 0) ? 1 : 0);
    end
    for (int i = 0; i < BL; i++) send(1'b0, 0);
    send(1'b1, 0);
    wait_drain();

    // Phase C: stalled output, capacity limit (R6 R7)
    rdy_mode = 2;
    repeat (3) begin @(posedge clk); #1; end
    for (int i = 0; i < 2 * BL; i++) send(1'b0, 0);
    in_valid = 1'b1;
    in_data  = seq;
    in_last  = 1'b0;
    for (int i = 0; i < BL; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R6", "in_ready with both banks held", in_ready, 0);
      chk(out_valid == 1'b1, "R7", "out_valid while stalled", out_valid, 1);
    end
    @(posedge clk);
    #1;
    rdy_mode = 0;
    for (int i = 0; i < BL; i++) send(1'b0, 0);
    wait_drain();

    // Phase D: random valid and ready gating with random markers
    rdy_mode = 1;
    for (int i = 0; i < 150; i++) begin
      lfsr_in = step(lfsr_in);
      send((lfsr_in[2:0] == 3'd0) || (i == 149), int'(lfsr_in[5:4]) % 3);
    end
    wait_drain();

    done = 1;
    summary();
    $finish;
  end

endmodule